// File: doc/BRIEF.md
# Error Record Mover

This engine moves one error record between a host-visible exchange buffer and a fixed-size slot in backing storage. The caller sets an operation (store or fetch), a byte offset into the exchange buffer and, for a fetch, a record identifier, then pulses `start`. Before it copies any byte, the engine validates the request. It checks the offset window and the record's own header: a 32-bit little-endian length and, on a store, a 64-bit little-endian identifier. Both come from fixed byte positions inside the record.

A store looks the identifier up in a slot directory. A match is rewritten in its own slot. Otherwise the lowest empty slot is claimed. Once the copy is done, the rest of the slot is padded with 0xFF bytes and the directory is updated. A fetch resolves the identifier: zero means the first stored record. It then reads the length from the stored slot and copies that many bytes to the exchange buffer at the offset. Both memories are external synchronous byte-wide RAMs with one cycle of read latency. The engine moves one byte per cycle and ends every operation with a one-cycle `done` pulse and a 3-bit status.

Top module: `errrec_mover`

## Requirements
- R1: An operation whose offset exceeds REC_BYTES−128 ends with status FAILED (3) and writes neither memory.
- R2: The record length is the 32-bit little-endian value at record bytes 20..23. A length below 128, or offset plus length above REC_BYTES, gives FAILED with no data written. For a fetch the length is taken from the stored slot.
- R3: On a store, the identifier is the 64-bit little-endian value at record bytes 96..103. An identifier of all zeros or all ones gives FAILED with no storage write.
- R4: A store of an identifier that is not yet present uses the lowest empty slot, whose bytes start at storage address slot×REC_BYTES. It copies the record there, raises the record count by one and reports SUCCESS (0).
- R5: A store of an identifier already present rewrites that same slot and leaves the record count unchanged.
- R6: A store of a new identifier when every slot is occupied reports NO_SPACE (1), writes no storage and leaves the count unchanged.
- R7: After a successful store, slot bytes from the record length up to REC_BYTES−1 hold 0xFF. Exactly REC_BYTES storage bytes are written.
- R8: A fetch while the record count is zero reports STORE_EMPTY (4).
- R9: A fetch with identifier zero uses the record in the lowest occupied slot, and `id_out` shows that identifier.
- R10: A fetch with an all-ones identifier, while records exist, reports FAILED.
- R11: A fetch of an absent identifier reports NOT_FOUND (5), writes nothing, and sets `id_out` to the first stored identifier.
- R12: A successful fetch writes exactly the stored length of bytes to the exchange buffer from the offset on, equal to the slot's bytes, and leaves the other exchange bytes untouched.
- R13: After reset `done`=0, `status`=0, `rec_count`=0 and `id_out`=0. `done` is a one-cycle pulse per accepted operation. `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_rd | input | 1 | 1 = fetch from storage, 0 = store into storage |
| rec_off | input | XA_W | Record byte offset in the exchange buffer |
| id_in | input | 64 | Identifier to fetch (ignored by a store) |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Completion code, valid with done |
| id_out | output | 64 | Identifier the last operation resolved to |
| rec_count | output | CNT_W | Number of occupied slots |
| xb_en | output | 1 | Exchange buffer access enable |
| xb_we | output | 1 | Exchange buffer write enable |
| xb_addr | output | XA_W | Exchange buffer byte address |
| xb_wdata | output | 8 | Exchange buffer write byte |
| xb_rdata | input | 8 | Exchange buffer read byte, one cycle after the access |
| st_en | output | 1 | Storage access enable |
| st_we | output | 1 | Storage write enable |
| st_addr | output | SA_W | Storage byte address (slot, byte) |
| st_wdata | output | 8 | Storage write byte |
| st_rdata | input | 8 | Storage read byte, one cycle after the access |

## Verification
A corrupted directory shows at the next operation that depends on it. A store then lands in the wrong slot or reports NO_SPACE too early, a fetch reports NOT_FOUND or returns the wrong first identifier, and `rec_count` drifts at that operation's `done`. A mistake in header assembly or in the bounds arithmetic shows within the same operation: the status code is wrong, or the number of bytes written to either memory is wrong. Counting the write strobes per operation, and comparing slot contents byte for byte, exposes off-by-one copy or padding errors in the very operation that has them.

// File: rtl/errrec_pkg.sv
package errrec_pkg;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_NOSPACE  = 3'd1,
        ST_FAIL     = 3'd3,
        ST_EMPTY    = 3'd4,
        ST_NOTFOUND = 3'd5
    } errrec_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_HDR,
        S_DECIDE,
        S_COPY,
        S_FILL
    } mv_state_e;

    localparam int MIN_REC = 128;   // smallest legal record in bytes
    localparam int LEN_POS = 20;    // byte position of the length field
    localparam int ID_POS  = 96;    // byte position of the identifier field

    localparam logic [63:0] ID_NONE = 64'h0;
    localparam logic [63:0] ID_END  = 64'hFFFF_FFFF_FFFF_FFFF;

endpackage

// File: rtl/errrec_dir.sv
module errrec_dir #(
    parameter int NSLOTS = 8,
    parameter int SLOT_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       key,
    input  logic              upd_en,
    input  logic [SLOT_W-1:0] upd_idx,
    input  logic [63:0]       upd_id,
    input  logic              upd_new,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_idx,
    output logic              has_free,
    output logic [SLOT_W-1:0] free_idx,
    output logic [63:0]       first_id,
    output logic [CNT_W-1:0]  count
);
    import errrec_pkg::*;

    logic [63:0]      ids_q [NSLOTS];
    logic [63:0]      ids_d [NSLOTS];
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [NSLOTS-1:0] match_v, empty_v;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        assign match_v[g] = (key != ID_NONE) && (ids_q[g] == key);
        assign empty_v[g] = (ids_q[g] == ID_NONE);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        first_id = ID_END;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            if (match_v[i]) begin
                hit     = 1'b1;
                hit_idx = SLOT_W'(i);
            end
            if (empty_v[i]) begin
                has_free = 1'b1;
                free_idx = SLOT_W'(i);
            end else begin
                first_id = ids_q[i];
            end
        end
    end

    always_comb begin
        ids_d = ids_q;
        cnt_d = cnt_q;
        if (upd_en) begin
            ids_d[upd_idx] = upd_id;
            if (upd_new) cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOTS; i++) ids_q[i] <= ID_NONE;
            cnt_q <= '0;
        end else begin
            ids_q <= ids_d;
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/errrec_hdr_chk.sv
module errrec_hdr_chk #(
    parameter int REC_BYTES = 256,
    parameter int XA_W      = 8
) (
    input  logic [XA_W-1:0] off,
    input  logic [31:0]     len,
    input  logic [63:0]     id,
    output logic            off_bad,
    output logic            len_bad,
    output logic            id_bad
);
    import errrec_pkg::*;

    logic [32:0] span;

    always_comb begin
        span    = {1'b0, len} + 33'(off);
        off_bad = 32'(off) > 32'(REC_BYTES - MIN_REC);
        len_bad = (len < 32'(MIN_REC)) || (span > 33'(REC_BYTES));
        id_bad  = (id == ID_NONE) || (id == ID_END);
    end

endmodule

// File: rtl/errrec_ctrl.sv
module errrec_ctrl #(
    parameter int REC_BYTES = 256,
    parameter int XA_W      = 8,
    parameter int SLOT_W    = 3,
    parameter int CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_rd,
    input  logic [XA_W-1:0]   off_in,
    input  logic [63:0]       id_in,
    input  logic [CNT_W-1:0]  count,
    input  logic              hit,
    input  logic [SLOT_W-1:0] hit_idx,
    input  logic              has_free,
    input  logic [SLOT_W-1:0] free_idx,
    input  logic [63:0]       first_id,
    input  logic              off_bad,
    input  logic              len_bad,
    input  logic              id_bad,
    output logic [XA_W-1:0]   cur_off,
    output logic [31:0]       cur_len,
    output logic [63:0]       cur_id,
    output logic              upd_en,
    output logic [SLOT_W-1:0] upd_idx,
    output logic [63:0]       upd_id,
    output logic              upd_new,
    output logic              done,
    output logic [2:0]        status,
    output logic              xb_en,
    output logic              xb_we,
    output logic [XA_W-1:0]   xb_addr,
    output logic [7:0]        xb_wdata,
    input  logic [7:0]        xb_rdata,
    output logic              st_en,
    output logic              st_we,
    output logic [SLOT_W+XA_W-1:0] st_addr,
    output logic [7:0]        st_wdata,
    input  logic [7:0]        st_rdata
);
    import errrec_pkg::*;

    typedef struct packed {
        mv_state_e         st;
        logic              rd_op;
        logic [XA_W-1:0]   off;
        logic [63:0]       id;
        logic [31:0]       len;
        logic [SLOT_W-1:0] slot;
        logic              is_new;
        logic [4:0]        k;
        logic              hpend;
        logic [4:0]        hk;
        logic [XA_W:0]     idx;
        logic              cpend;
        logic [XA_W-1:0]   cidx;
        logic              done;
        logic [2:0]        status;
    } ctl_t;

    ctl_t r_q, r_d;

    logic [4:0]      nk;
    logic [XA_W-1:0] hoff;
    logic [2:0]      hk_rel;
    logic [7:0]      hbyte;

    assign nk     = r_q.rd_op ? 5'd4 : 5'd12;
    assign hoff   = (r_q.k < 5'd4) ? XA_W'(LEN_POS + int'(r_q.k))
                                   : XA_W'(ID_POS + int'(r_q.k) - 4);
    assign hk_rel = 3'(r_q.hk - 5'd4);
    assign hbyte  = r_q.rd_op ? st_rdata : xb_rdata;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        xb_en = 1'b0; xb_we = 1'b0; xb_addr = '0; xb_wdata = '0;
        st_en = 1'b0; st_we = 1'b0; st_addr = '0; st_wdata = '0;
        upd_en = 1'b0; upd_idx = r_q.slot; upd_id = r_q.id; upd_new = r_q.is_new;

        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_CHECK;
                    r_d.rd_op = op_rd;
                    r_d.off   = off_in;
                    r_d.len   = '0;
                    r_d.id    = (op_rd && id_in == ID_NONE) ? first_id : id_in;
                end
            end
            S_CHECK: begin
                r_d.k     = '0;
                r_d.hpend = 1'b0;
                if (r_q.rd_op) begin
                    if (count == '0) begin
                        r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_EMPTY;
                    end else if (r_q.id == ID_END || off_bad) begin
                        r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_FAIL;
                    end else if (!hit) begin
                        r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_NOTFOUND;
                        r_d.id = first_id;
                    end else begin
                        r_d.slot = hit_idx;
                        r_d.st   = S_HDR;
                    end
                end else if (off_bad) begin
                    r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_FAIL;
                end else begin
                    r_d.st = S_HDR;
                end
            end
            S_HDR: begin
                if (r_q.k < nk) begin
                    if (r_q.rd_op) begin
                        st_en   = 1'b1;
                        st_addr = {r_q.slot, hoff};
                    end else begin
                        xb_en   = 1'b1;
                        xb_addr = r_q.off + hoff;
                    end
                    r_d.k     = r_q.k + 5'd1;
                    r_d.hpend = 1'b1;
                    r_d.hk    = r_q.k;
                end else begin
                    r_d.hpend = 1'b0;
                end
                if (r_q.hpend) begin
                    if (r_q.hk < 5'd4) r_d.len[{r_q.hk[1:0], 3'b000} +: 8] = hbyte;
                    else               r_d.id[{hk_rel, 3'b000} +: 8]      = hbyte;
                    if (r_q.hk == nk - 5'd1) r_d.st = S_DECIDE;
                end
            end
            S_DECIDE: begin
                r_d.idx   = '0;
                r_d.cpend = 1'b0;
                if (len_bad || (!r_q.rd_op && id_bad)) begin
                    r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_FAIL;
                end else if (r_q.rd_op) begin
                    r_d.st = S_COPY;
                end else if (hit) begin
                    r_d.slot = hit_idx; r_d.is_new = 1'b0; r_d.st = S_COPY;
                end else if (has_free) begin
                    r_d.slot = free_idx; r_d.is_new = 1'b1; r_d.st = S_COPY;
                end else begin
                    r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_NOSPACE;
                end
            end
            S_COPY: begin
                if (32'(r_q.idx) < r_q.len) begin
                    if (r_q.rd_op) begin
                        st_en   = 1'b1;
                        st_addr = {r_q.slot, r_q.idx[XA_W-1:0]};
                    end else begin
                        xb_en   = 1'b1;
                        xb_addr = r_q.off + r_q.idx[XA_W-1:0];
                    end
                    r_d.cpend = 1'b1;
                    r_d.cidx  = r_q.idx[XA_W-1:0];
                    r_d.idx   = r_q.idx + 1'b1;
                end else begin
                    r_d.cpend = 1'b0;
                end
                if (r_q.cpend) begin
                    if (r_q.rd_op) begin
                        xb_en    = 1'b1;
                        xb_we    = 1'b1;
                        xb_addr  = r_q.off + r_q.cidx;
                        xb_wdata = st_rdata;
                    end else begin
                        st_en    = 1'b1;
                        st_we    = 1'b1;
                        st_addr  = {r_q.slot, r_q.cidx};
                        st_wdata = xb_rdata;
                    end
                    if (32'(r_q.cidx) == r_q.len - 32'd1) begin
                        if (r_q.rd_op) begin
                            r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_OK;
                        end else if (r_q.len < 32'(REC_BYTES)) begin
                            r_d.st  = S_FILL;
                            r_d.idx = r_q.len[XA_W:0];
                        end else begin
                            upd_en = 1'b1;
                            r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_OK;
                        end
                    end
                end
            end
            S_FILL: begin
                st_en    = 1'b1;
                st_we    = 1'b1;
                st_addr  = {r_q.slot, r_q.idx[XA_W-1:0]};
                st_wdata = 8'hFF;
                r_d.idx  = r_q.idx + 1'b1;
                if (r_q.idx == (XA_W+1)'(REC_BYTES - 1)) begin
                    upd_en = 1'b1;
                    r_d.st = S_IDLE; r_d.done = 1'b1; r_d.status = ST_OK;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.status <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_off = r_q.off;
    assign cur_len = r_q.len;
    assign cur_id  = r_q.id;
    assign done    = r_q.done;
    assign status  = r_q.status;

endmodule

// File: rtl/errrec_mover.sv
module errrec_mover #(
    parameter int REC_BYTES = 256,
    parameter int NSLOTS    = 8,
    localparam int XA_W   = $clog2(REC_BYTES),
    localparam int SLOT_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
    localparam int SA_W   = SLOT_W + XA_W,
    localparam int CNT_W  = $clog2(NSLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_rd,
    input  logic [XA_W-1:0]  rec_off,
    input  logic [63:0]      id_in,
    output logic             done,
    output logic [2:0]       status,
    output logic [63:0]      id_out,
    output logic [CNT_W-1:0] rec_count,
    output logic             xb_en,
    output logic             xb_we,
    output logic [XA_W-1:0]  xb_addr,
    output logic [7:0]       xb_wdata,
    input  logic [7:0]       xb_rdata,
    output logic             st_en,
    output logic             st_we,
    output logic [SA_W-1:0]  st_addr,
    output logic [7:0]       st_wdata,
    input  logic [7:0]       st_rdata
);
    logic              hit, has_free, upd_en, upd_new;
    logic [SLOT_W-1:0] hit_idx, free_idx, upd_idx;
    logic [63:0]       first_id, upd_id, cur_id;
    logic [XA_W-1:0]   cur_off;
    logic [31:0]       cur_len;
    logic              off_bad, len_bad, id_bad;

    errrec_dir #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .key(cur_id),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_id(upd_id), .upd_new(upd_new),
        .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx),
        .first_id(first_id), .count(rec_count)
    );

    errrec_hdr_chk #(.REC_BYTES(REC_BYTES), .XA_W(XA_W)) u_chk (
        .off(cur_off), .len(cur_len), .id(cur_id),
        .off_bad(off_bad), .len_bad(len_bad), .id_bad(id_bad)
    );

    errrec_ctrl #(.REC_BYTES(REC_BYTES), .XA_W(XA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_rd(op_rd),
        .off_in(rec_off), .id_in(id_in), .count(rec_count),
        .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx),
        .first_id(first_id), .off_bad(off_bad), .len_bad(len_bad), .id_bad(id_bad),
        .cur_off(cur_off), .cur_len(cur_len), .cur_id(cur_id),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_id(upd_id), .upd_new(upd_new),
        .done(done), .status(status),
        .xb_en(xb_en), .xb_we(xb_we), .xb_addr(xb_addr), .xb_wdata(xb_wdata), .xb_rdata(xb_rdata),
        .st_en(st_en), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    assign id_out = cur_id;

endmodule

// File: rtl/errrec_mover_chk.sv
module errrec_mover_chk #(
    parameter int NSLOTS = 8,
    parameter int CNT_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_rd,
    input logic             done,
    input logic [2:0]       status,
    input logic [CNT_W-1:0] rec_count,
    input logic             xb_en,
    input logic             xb_we,
    input logic             st_en,
    input logic             st_we
);
    logic busy_q, rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
        end else if (start && (!busy_q || done)) begin
            busy_q <= 1'b1;
            rd_q   <= op_rd;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // R4
    store_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && st_we) |-> (busy_q && !rd_q));

    // R12
    fetch_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_en && xb_we) |-> (busy_q && rd_q));

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_count != $past(rec_count)) |->
            (done && status == 3'd0 && rec_count == $past(rec_count) + CNT_W'(1)));

    // R6
    nospace_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd1) |-> (rec_count == CNT_W'(NSLOTS)));

    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd4) |-> (rec_count == '0));

endmodule

bind errrec_mover errrec_mover_chk #(.NSLOTS(NSLOTS), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_rd(op_rd), .done(done),
    .status(status), .rec_count(rec_count), .xb_en(xb_en), .xb_we(xb_we),
    .st_en(st_en), .st_we(st_we)
);

// File: tb/test_errrec_mover.sv
module test_errrec_mover;
    localparam int REC = 256;
    localparam int NS  = 4;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, op_rd = 1'b0;
    logic [7:0] rec_off = '0;
    logic [63:0] id_in = '0, id_out;
    logic done;
    logic [2:0] status;
    logic [2:0] rec_count;
    logic xb_en, xb_we, st_en, st_we;
    logic [7:0] xb_addr, xb_wdata, st_wdata;
    logic [7:0] xb_rdata = '0, st_rdata = '0;
    logic [9:0] st_addr;

    logic [7:0] xbm [REC];
    logic [7:0] stm [NS*REC];
    logic h_xb_we = 1'b0, h_st_we = 1'b0, wc_clr = 1'b0;
    logic [9:0] h_addr = '0;
    logic [7:0] h_data = '0;
    int xb_wc = 0, st_wc = 0, done_c = 0;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    errrec_mover #(.REC_BYTES(REC), .NSLOTS(NS)) i_errrec_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .op_rd(op_rd), .rec_off(rec_off),
        .id_in(id_in), .done(done), .status(status), .id_out(id_out), .rec_count(rec_count),
        .xb_en(xb_en), .xb_we(xb_we), .xb_addr(xb_addr), .xb_wdata(xb_wdata), .xb_rdata(xb_rdata),
        .st_en(st_en), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    always @(posedge clk) begin
        if (xb_en) begin
            if (xb_we) xbm[xb_addr] <= xb_wdata;
            xb_rdata <= xbm[xb_addr];
        end else if (h_xb_we) xbm[h_addr[7:0]] <= h_data;
        if (st_en) begin
            if (st_we) stm[st_addr] <= st_wdata;
            st_rdata <= stm[st_addr];
        end else if (h_st_we) stm[h_addr] <= h_data;
        if (wc_clr) begin
            xb_wc <= 0; st_wc <= 0; done_c <= 0;
        end else begin
            if (xb_en && xb_we) xb_wc <= xb_wc + 1;
            if (st_en && st_we) st_wc <= st_wc + 1;
            if (done) done_c <= done_c + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] xb_byte(int a, int off, int len, logic [63:0] id);
        int rel;
        logic [31:0] l;
        rel = a - off;
        l = 32'(len);
        if (a < off || rel >= len) return 8'h00;
        if (rel >= 20 && rel < 24) return l[(rel-20)*8 +: 8];
        if (rel >= 96 && rel < 104) return id[(rel-96)*8 +: 8];
        return 8'(rel * 7 + 3) ^ id[7:0];
    endfunction

    task automatic host_wr(input bit to_st, input int a, input logic [7:0] d);
        h_addr = 10'(a); h_data = d;
        h_xb_we = !to_st; h_st_we = to_st;
        @(negedge clk);
        h_xb_we = 1'b0; h_st_we = 1'b0;
    endtask

    task automatic clear_counts();
        wc_clr = 1'b1;
        @(negedge clk);
        wc_clr = 1'b0;
    endtask

    task automatic launch(input bit rd, input int off, input logic [63:0] id);
        clear_counts();
        start = 1'b1; op_rd = rd; rec_off = 8'(off); id_in = id;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, "done seen", 64'(done), 64'd1);
    endtask

    // {op, off, len, id, status, count, slot, id_out}
    localparam int VW = 162;
    localparam int NV = 17;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 8'd0,   16'd0,   64'h5,  3'd4, 4'd0, 2'd0, 64'h0 },  // R8  fetch from empty store
        {1'b0, 8'd200, 16'd160, 64'hA1, 3'd3, 4'd0, 2'd0, 64'h0 },  // R1  offset past window
        {1'b0, 8'd0,   16'd100, 64'hA2, 3'd3, 4'd0, 2'd0, 64'h0 },  // R2  length below minimum
        {1'b0, 8'd64,  16'd200, 64'hA3, 3'd3, 4'd0, 2'd0, 64'h0 },  // R2  record overruns buffer
        {1'b0, 8'd0,   16'd128, 64'h0,  3'd3, 4'd0, 2'd0, 64'h0 },  // R3  zero identifier
        {1'b0, 8'd0,   16'd128, ONES,   3'd3, 4'd0, 2'd0, 64'h0 },  // R3  all-ones identifier
        {1'b0, 8'd0,   16'd160, 64'h11, 3'd0, 4'd1, 2'd0, 64'h11},  // R4  first slot
        {1'b0, 8'd16,  16'd200, 64'h22, 3'd0, 4'd2, 2'd1, 64'h22},  // R4  next slot
        {1'b0, 8'd128, 16'd128, 64'h33, 3'd0, 4'd3, 2'd2, 64'h33},  // R4  ends exactly at buffer end
        {1'b0, 8'd0,   16'd130, 64'h44, 3'd0, 4'd4, 2'd3, 64'h44},  // R4  last slot
        {1'b0, 8'd0,   16'd140, 64'h55, 3'd1, 4'd4, 2'd0, 64'h0 },  // R6  store full
        {1'b0, 8'd0,   16'd150, 64'h22, 3'd0, 4'd4, 2'd1, 64'h22},  // R5 R7 shorter rewrite
        {1'b1, 8'd0,   16'd128, 64'h33, 3'd0, 4'd4, 2'd2, 64'h33},  // R12 fetch
        {1'b1, 8'd0,   16'd0,   64'h99, 3'd5, 4'd4, 2'd0, 64'h11},  // R11 absent identifier
        {1'b1, 8'd0,   16'd0,   ONES,   3'd3, 4'd4, 2'd0, 64'h0 },  // R10 all-ones fetch
        {1'b1, 8'd32,  16'd160, 64'h0,  3'd0, 4'd4, 2'd0, 64'h11},  // R9  zero means first
        {1'b1, 8'd200, 16'd0,   64'h44, 3'd3, 4'd4, 2'd0, 64'h0 }   // R1  fetch offset past window
    };
    localparam int VREQ [NV] = '{8, 1, 2, 2, 3, 3, 4, 4, 4, 4, 6, 5, 12, 11, 10, 9, 1};

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < NS*REC; a++) stm[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(done == 1'b0 && status == 3'd0, "R13", "reset done/status", {61'd0, status}, 64'd0);
        chk(rec_count == 3'd0 && id_out == 64'd0, "R13", "reset count/id", 64'(rec_count), 64'd0);
        chk(!xb_en && !st_en, "R13", "reset memory idle", {62'd0, xb_en, st_en}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            bit rd;
            int off, len, slot, mism;
            logic [63:0] id, xid;
            logic [2:0] est;
            logic [3:0] ecnt;
            string tag;
            e = VEC[v];
            rd = e[161]; off = int'(e[160:153]); len = int'(e[152:137]); id = e[136:73];
            est = e[72:70]; ecnt = e[69:66]; slot = int'(e[65:64]); xid = e[63:0];
            tag = $sformatf("R%0d", VREQ[v]);
            for (int a = 0; a < REC; a++)
                host_wr(1'b0, a, rd ? 8'hA5 : xb_byte(a, off, len, id));
            launch(rd, off, id);
            wait_done(tag);
            chk(status == est, tag, $sformatf("vector %0d status", v), 64'(status), 64'(est));
            chk(32'(rec_count) == 32'(ecnt), tag, $sformatf("vector %0d count", v), 64'(rec_count), 64'(ecnt));
            if (est == 3'd0 || est == 3'd5)
                chk(id_out == xid, tag, $sformatf("vector %0d id_out", v), id_out, xid);
            @(negedge clk);
            chk(done == 1'b0, "R13", "done one cycle", 64'(done), 64'd0);
            if (!rd && est == 3'd0) begin
                mism = 0;
                for (int i = 0; i < REC; i++)
                    if (stm[slot*REC+i] !== ((i < len) ? xbm[off+i] : 8'hFF)) mism++;
                chk(mism == 0, tag, "slot image incl. R7 padding", 64'(mism), 64'd0);
                chk(st_wc == REC, "R7", "storage writes", 64'(st_wc), 64'(REC));
            end else if (rd && est == 3'd0) begin
                mism = 0;
                for (int a = 0; a < REC; a++)
                    if (a >= off && a < off + len) begin
                        if (xbm[a] !== stm[slot*REC + a - off]) mism++;
                    end else if (xbm[a] !== 8'hA5) mism++;
                chk(mism == 0, tag, "exchange image", 64'(mism), 64'd0);
                chk(xb_wc == len, tag, "exchange writes", 64'(xb_wc), 64'(len));
            end else begin
                chk(st_wc == 0 && xb_wc == 0, tag, "no writes on reject", 64'(st_wc + xb_wc), 64'd0);
            end
        end

        // R2 length taken from the stored slot: corrupt slot 2 length to 100
        host_wr(1'b1, 2*REC + 20, 8'd100);
        host_wr(1'b1, 2*REC + 21, 8'd0);
        launch(1'b1, 0, 64'h33);
        wait_done("R2");
        chk(status == 3'd3, "R2", "stored short length", 64'(status), 64'd3);
        chk(xb_wc == 0, "R2", "no exchange writes", 64'(xb_wc), 64'd0);

        // R13 second start while busy is ignored; slot 1 holds 150 bytes (R5)
        for (int a = 0; a < REC; a++) host_wr(1'b0, a, 8'hA5);
        launch(1'b1, 0, 64'h22);
        repeat (5) @(negedge clk);
        start = 1'b1; op_rd = 1'b0; id_in = 64'h77;
        @(negedge clk);
        start = 1'b0;
        wait_done("R13");
        chk(status == 3'd0, "R13", "busy fetch status", 64'(status), 64'd0);
        repeat (400) @(negedge clk);
        chk(done_c == 1, "R13", "single completion", 64'(done_c), 64'd1);
        chk(xb_wc == 150 && st_wc == 0, "R5", "rewritten length fetched", 64'(xb_wc), 64'd150);
        chk(rec_count == 3'd4, "R13", "count after ignored start", 64'(rec_count), 64'd4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule